// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between an on-chip requester and an external 16-bit asynchronous static RAM of 256K words. A requester presents a word address, a read/write flag, write data and a two-bit byte-enable mask under a valid/ready handshake. The controller turns each request into a pin-level read or write cycle. It returns read data with a one-cycle valid pulse.

Each timing minimum of the memory is converted into a whole number of clock cycles. The conversion takes a clock-period parameter and rounds up, so the same code meets the device limits at any clock rate. After reset the controller keeps the memory deselected for a fixed power-up interval, and it accepts no request until that interval is over. A request is carried out one access at a time. Between two accesses there is always a cycle with the memory deselected.

The data bus is split into an output value, an output-enable and an input value, so the pad ring can build the tristate buffer.

Top module: `sram_lane_ctrl`

## Requirements
- R1: For PWR_CYC = ceil(T_PWRUP_PS / CLK_PS) clock edges after reset is released, `req_ready` is low, `mem_cs_n` is high and `mem_cs2` is low. `req_ready` first reads high after exactly PWR_CYC edges, and after that `mem_cs2` stays high.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` stays low until that access has finished. `req_ready` returns high 2 cycles after a request with no byte enable, RD_CYC+2 cycles after a read, and WE_CYC+3 cycles after a write.
- R3: The memory is selected (`mem_cs_n` low with `mem_cs2` high) only during an access. At all other times `mem_cs_n`, `mem_oe_n`, `mem_we_n`, both byte strobes and `mem_dq_oe` are inactive.
- R4: While the memory is selected, `mem_lb_n` is low exactly when `req_be[0]` was set, and `mem_ub_n` is low exactly when `req_be[1]` was set. Bit 0 covers data bits 7:0 and bit 1 covers bits 15:8. A request with both enables clear is accepted but never selects the memory, and it returns no response.
- R5: A read holds `mem_oe_n` low, with `mem_we_n` high and the memory selected, for exactly RD_CYC = ceil(T_RC_PS / CLK_PS) cycles.
- R6: `rsp_rdata` carries the value of `mem_dq_in` sampled on the last cycle that `mem_oe_n` is low. `rsp_valid` is high for exactly the one following cycle.
- R7: A write starts with one cycle selected and `mem_we_n` high. Then `mem_we_n` is low for exactly WE_CYC = max(ceil(T_WP_PS/CLK_PS), ceil(T_WC_PS/CLK_PS)-2, ceil(T_AW_PS/CLK_PS)-1) cycles. `mem_oe_n` stays high for the whole write.
- R8: `mem_dq_oe` is high exactly while `mem_we_n` is low, and during that window `mem_dq_out` equals the request's write data. The bus is released on the same edge that ends the write pulse.
- R9: Every access ends with one cycle in which `mem_cs_n`, `mem_oe_n` and `mem_we_n` are all high, before `req_ready` rises again.
- R10: `mem_addr` equals the request address and does not change while the memory is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 18 | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| mem_addr | output | 18 | Memory address pins |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high second chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_ub_n | output | 1 | Active-low strobe for bits 15:8 |
| mem_lb_n | output | 1 | Active-low strobe for bits 7:0 |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data bus driver |
| mem_dq_in | input | 16 | Data arriving from the memory |

## Verification
The hardest case to reach is a partial-lane read that follows partial-lane writes to the same word. The returned value is only right if the disabled lane was never touched by any earlier strobe. To reach it, the bench first writes every address in a small window as a full word. It then overwrites one lane at a time with different values and reads each address back under all four enable masks. A behavioural memory in the bench answers the pins, so lane corruption shows up in the comparison.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WS   = 3'd2,
    ST_WP   = 3'd3,
    ST_GAP  = 3'd4
  } seq_state_t;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_pwrup_timer.sv
module sram_pwrup_timer #(
  parameter int HOLD_CYC = 20000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!done_q) begin
      if (cnt_q == CW'(HOLD_CYC - 1)) done_d = 1'b1;
      else                            cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC = 7,
  parameter int WE_CYC = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       start_wr_i,
  input  logic       start_none_i,
  output seq_state_t state_o,
  output logic       last_o
);
  localparam int MAXC = imax(RD_CYC, WE_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  seq_state_t    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        if (start_none_i)    st_d = ST_GAP;
        else if (start_wr_i) st_d = ST_WS;
        else begin
          st_d  = ST_RD;
          cnt_d = CW'(RD_CYC - 1);
        end
      end
      ST_RD: begin
        if (cnt_q == '0) st_d = ST_GAP;
        else             cnt_d = cnt_q - 1'b1;
      end
      ST_WS: begin
        st_d  = ST_WP;
        cnt_d = CW'(WE_CYC - 1);
      end
      ST_WP: begin
        if (cnt_q == '0) st_d = ST_GAP;
        else             cnt_d = cnt_q - 1'b1;
      end
      ST_GAP:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o = st_q;
  assign last_o  = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_drv.sv
module sram_lane_drv
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  seq_state_t        state_i,
  input  logic              last_i,
  input  logic              pwr_done_i,
  input  logic [DATA_W-1:0] dq_in_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cs_n_o,
  output logic              cs2_o,
  output logic              oe_n_o,
  output logic              we_n_o,
  output logic [DATA_W/8-1:0] strobe_n_o,
  output logic [DATA_W-1:0] dq_out_o,
  output logic              dq_oe_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [LANES-1:0]  be_q;
  logic              rvld_q, rvld_d, capture, sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      be_q    <= be_i;
    end
  end

  assign sel     = (state_i == ST_RD) || (state_i == ST_WS) || (state_i == ST_WP);
  assign capture = (state_i == ST_RD) && last_i;
  assign rvld_d  = capture;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      rvld_q  <= 1'b0;
    end else begin
      rvld_q <= rvld_d;
      if (capture) rdata_q <= dq_in_i;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign strobe_n_o[i] = !(sel && be_q[i]);
  end

  assign addr_o      = addr_q;
  assign cs_n_o      = !sel;
  assign cs2_o       = pwr_done_i;
  assign oe_n_o      = (state_i != ST_RD);
  assign we_n_o      = (state_i != ST_WP);
  assign dq_oe_o     = (state_i == ST_WP);
  assign dq_out_o    = wdata_q;
  assign rsp_valid_o = rvld_q;
  assign rsp_rdata_o = rdata_q;
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 16,
  parameter int CLK_PS     = 10000,
  parameter int T_PWRUP_PS = 200000000,
  parameter int T_RC_PS    = 70000,
  parameter int T_WC_PS    = 70000,
  parameter int T_WP_PS    = 50000,
  parameter int T_AW_PS    = 60000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int PWR_CYC = cdiv(T_PWRUP_PS, CLK_PS);
  localparam int RD_CYC  = cdiv(T_RC_PS, CLK_PS);
  localparam int WE_CYC  = imax(cdiv(T_WP_PS, CLK_PS),
                                imax(cdiv(T_WC_PS, CLK_PS) - 2, cdiv(T_AW_PS, CLK_PS) - 1));

  seq_state_t state;
  logic       last, pwr_done, accept;
  logic [1:0] strobe_n;

  assign req_ready = pwr_done && (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  sram_pwrup_timer #(.HOLD_CYC(PWR_CYC)) u_pwrup (
    .clk    (clk),
    .rst_n  (rst_n),
    .done_o (pwr_done)
  );

  sram_phase_seq #(.RD_CYC(RD_CYC), .WE_CYC(WE_CYC)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (accept),
    .start_wr_i   (req_write),
    .start_none_i (req_be == 2'b00),
    .state_o      (state),
    .last_o       (last)
  );

  sram_lane_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .addr_i      (req_addr),
    .wdata_i     (req_wdata),
    .be_i        (req_be),
    .state_i     (state),
    .last_i      (last),
    .pwr_done_i  (pwr_done),
    .dq_in_i     (mem_dq_in),
    .addr_o      (mem_addr),
    .cs_n_o      (mem_cs_n),
    .cs2_o       (mem_cs2),
    .oe_n_o      (mem_oe_n),
    .we_n_o      (mem_we_n),
    .strobe_n_o  (strobe_n),
    .dq_out_o    (mem_dq_out),
    .dq_oe_o     (mem_dq_oe),
    .rsp_valid_o (rsp_valid),
    .rsp_rdata_o (rsp_rdata)
  );

  assign mem_lb_n = strobe_n[0];
  assign mem_ub_n = strobe_n[1];
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int PWR_CYC = 20000,
  parameter int WE_CYC  = 5,
  parameter int ADDR_W  = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_cs_n,
  input logic              mem_cs2,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_ub_n,
  input logic              mem_lb_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr
);
  localparam int SW = $clog2(PWR_CYC + 1);

  logic [SW-1:0] since_rst;
  logic [15:0]   we_lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      we_lo_cnt <= '0;
    end else begin
      if (since_rst < SW'(PWR_CYC)) since_rst <= since_rst + 1'b1;
      if (!mem_we_n) begin
        if (we_lo_cnt != 16'hFFFF) we_lo_cnt <= we_lo_cnt + 1'b1;
      end else begin
        we_lo_cnt <= '0;
      end
    end
  end

  assert_pwrup_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < SW'(PWR_CYC)) |-> (mem_cs_n && !req_ready));

  assert_select_only_when_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_ub_n && mem_lb_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  assert_we_needs_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_cs2));

  assert_some_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !(mem_ub_n && mem_lb_n));

  assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_oe_we_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  assert_we_pulse_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_cnt >= 16'(WE_CYC)));

  assert_drive_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n));

  assert_gap_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_cs_n && mem_oe_n));

  assert_gap_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> mem_cs_n);

  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .PWR_CYC (PWR_CYC),
  .WE_CYC  (WE_CYC),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_cs_n  (mem_cs_n),
  .mem_cs2   (mem_cs2),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_ub_n  (mem_ub_n),
  .mem_lb_n  (mem_lb_n),
  .mem_dq_oe (mem_dq_oe),
  .mem_addr  (mem_addr)
);

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;
  localparam int CLK  = 8000;
  localparam int TPWR = 400000;
  localparam int PWR  = (TPWR + CLK - 1) / CLK;
  localparam int RD   = (70000 + CLK - 1) / CLK;
  localparam int WP0  = (50000 + CLK - 1) / CLK;
  localparam int WC0  = (70000 + CLK - 1) / CLK - 2;
  localparam int AW0  = (60000 + CLK - 1) / CLK - 1;
  localparam int WE   = (WP0 > WC0) ? ((WP0 > AW0) ? WP0 : AW0) : ((WC0 > AW0) ? WC0 : AW0);

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write, rsp_valid;
  logic [17:0] req_addr, mem_addr;
  logic [15:0] req_wdata, rsp_rdata, mem_dq_out, mem_dq_in;
  logic [1:0]  req_be;
  logic        mem_cs_n, mem_cs2, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] sram   [0:63];
  logic [15:0] golden [0:63];

  sram_lane_ctrl #(.CLK_PS(CLK), .T_PWRUP_PS(TPWR)) i_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs2(mem_cs2),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n),
    .mem_lb_n(mem_lb_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural memory answering the pins
  always_comb begin
    mem_dq_in = 16'h0000;
    if (!mem_cs_n && mem_cs2 && !mem_oe_n && mem_we_n) begin
      if (!mem_lb_n) mem_dq_in[7:0]  = sram[mem_addr[5:0]][7:0];
      if (!mem_ub_n) mem_dq_in[15:8] = sram[mem_addr[5:0]][15:8];
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) sram[i] <= 16'h0000;
    end else if (!mem_cs_n && mem_cs2 && !mem_we_n && mem_dq_oe) begin
      if (!mem_lb_n) sram[mem_addr[5:0]][7:0]  <= mem_dq_out[7:0];
      if (!mem_ub_n) sram[mem_addr[5:0]][15:8] <= mem_dq_out[15:8];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] be);
    int k, oe_lo, we_lo, cs_lo, rsp_at, rsp_n, first_we;
    bit addr_ok, strobe_ok, drv_ok, busy_ok;
    logic l_cs, l_oe, l_we;
    logic [15:0] got, m;
    k = 0; oe_lo = 0; we_lo = 0; cs_lo = 0; rsp_at = 0; rsp_n = 0; first_we = 0;
    addr_ok = 1; strobe_ok = 1; drv_ok = 1; busy_ok = 1;
    l_cs = 0; l_oe = 0; l_we = 0; got = '0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    k = 1;
    while (!req_ready && k < 40) begin
      if (!mem_oe_n) oe_lo++;
      if (!mem_we_n) begin
        we_lo++;
        if (first_we == 0) first_we = k;
      end
      if (!mem_cs_n) begin
        cs_lo++;
        if (mem_addr !== a) addr_ok = 0;
        if ({mem_ub_n, mem_lb_n} !== ~be) strobe_ok = 0;
        if (!mem_cs2) strobe_ok = 0;
      end
      if (mem_dq_oe !== !mem_we_n) drv_ok = 0;
      if (mem_dq_oe && mem_dq_out !== d) drv_ok = 0;
      if (rsp_valid) begin
        rsp_at = k; rsp_n++; got = rsp_rdata;
      end
      l_cs = mem_cs_n; l_oe = mem_oe_n; l_we = mem_we_n;
      k++;
      @(negedge clk);
    end
    chk("R2 cycles until ready", k,
        (be == 2'b00) ? 2 : (wr ? WE + 3 : RD + 2));
    chk("R9 closing idle cycle", {l_cs, l_oe, l_we}, 3'b111);
    chk("R10 address held", addr_ok, 1);
    chk("R4 lane strobes", strobe_ok, 1);
    m = {{8{be[1]}}, {8{be[0]}}};
    if (be == 2'b00) begin
      chk("R4 empty mask never selects", cs_lo, 0);
      chk("R4 empty mask no response", rsp_n, 0);
    end else if (!wr) begin
      chk("R5 oe low cycles", oe_lo, RD);
      chk("R5 no write pulse on read", we_lo, 0);
      chk("R3 select span on read", cs_lo, RD);
      chk("R6 response cycle", rsp_at, RD + 1);
      chk("R6 single pulse", rsp_n, 1);
      chk("R6 read data", got & m, golden[a[5:0]] & m);
    end else begin
      chk("R7 we low cycles", we_lo, WE);
      chk("R7 setup cycle before pulse", first_we, 2);
      chk("R7 oe high during write", oe_lo, 0);
      chk("R3 select span on write", cs_lo, WE + 1);
      chk("R8 bus drive window", drv_ok, 1);
      golden[a[5:0]] = (golden[a[5:0]] & ~m) | (d & m);
    end
  endtask

  initial begin
    logic [1:0] be_seq [0:3];
    be_seq[0] = 2'b11; be_seq[1] = 2'b01; be_seq[2] = 2'b10; be_seq[3] = 2'b00;
    for (int i = 0; i < 64; i++) golden[i] = 16'h0000;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_be = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", req_ready, 0);
    chk("R3 reset deselect", {mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe}, 6'b111110);
    chk("R6 reset rsp_valid", rsp_valid, 0);
    // a request waiting during power-up must be held off
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00005; req_wdata = 16'hDEAD; req_be = 2'b11;
    rst_n = 1'b1;
    for (int k = 1; k <= PWR; k++) begin
      @(negedge clk);
      if (k < PWR) begin
        chk("R1 ready held low", req_ready, 0);
        chk("R1 deselected during hold", {mem_cs_n, mem_cs2}, 2'b10);
      end else begin
        chk("R1 ready after hold", req_ready, 1);
        chk("R1 second select high", mem_cs2, 1);
      end
      if (k == PWR - 1) req_valid = 1'b0;
    end
    // full words first, then single lanes, then empty masks
    for (int b = 0; b < 4; b++) begin
      for (int a = 0; a < 16; a++) begin
        access(1'b1, {a[5:0], 6'b101010, a[5:0]},
               16'(a * 16'h0F1D) ^ {8'(b * 37), 8'(b * 91 + a)}, be_seq[b]);
      end
    end
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 4; b++) begin
        access(1'b0, {a[5:0], 6'b101010, a[5:0]}, 16'h0000, be_seq[b]);
      end
    end
    // back-to-back write then read of a single lane
    access(1'b1, 18'h3FFC0, 16'hA55A, 2'b10);
    access(1'b0, 18'h3FFC0, 16'h0000, 2'b11);
    access(1'b1, 18'h3FFC0, 16'h1234, 2'b01);
    access(1'b0, 18'h3FFC0, 16'h0000, 2'b11);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule